// File: doc/BRIEF.md
# Transmit Frame Segmenter

The segmenter sits between a transmit byte FIFO and a downstream link framer. Bytes pass through unchanged under a valid/ready handshake, and each accepted byte is tagged with a start-of-frame and an end-of-frame marker. The framer uses these markers to place flags and checksums around each frame.

Software programs a 13-bit maximum frame length and an automatic segmentation enable through a small register port. With segmentation on and a nonzero length, a long transfer is cut into back-to-back frames of exactly that length. The final piece may be shorter and ends where the source marks the end of data. With segmentation off, or with a length of zero, the whole transfer forms one frame.

The length and the enable are sampled when a frame's first byte is accepted, so a frame is never reshaped halfway through. Reading the length registers gives the number of bytes the current frame still has to send. Between frames the read gives the programmed length.

Top module: `tx_frame_segmenter`

## Requirements
- R1: After reset, every register address reads 0, `s_ready` equals `m_ready`, and the first byte accepted carries `m_sof`=1.
- R2: Register map. Address 0 holds length bits 7:0. Address 1 holds length bits 12:8 in write-data bits 4:0, and its upper three bits are ignored and read 0. Address 2 bit 0 is the segmentation enable, and its other bits read 0. Address 3 reads 0.
- R3: With the enable at 1 and a programmed length N>0, the Nth byte of a frame carries `m_eof`=1 and the next accepted byte carries `m_sof`=1.
- R4: A byte accepted with `s_last`=1 always carries `m_eof`=1, so the final frame of a split transfer can be shorter than N.
- R5: With the enable at 0, only `s_last` ends a frame, whatever length is programmed.
- R6: A programmed length of 0 with the enable at 1 behaves as no segmentation.
- R7: Reading addresses 0/1 between frames returns the programmed length. Inside a segmented frame, it returns the length captured at frame start minus the bytes accepted so far in that frame. Inside an unsegmented frame, it returns 0.
- R8: Writes to the length or the enable while a frame is open do not change that frame. They apply from the next frame start.
- R9: A byte moves only when `s_valid` and `m_ready` are both 1. `m_valid`=`s_valid`, `s_ready`=`m_ready` and `m_data`=`s_data`, and a stalled cycle changes neither the count nor the frame state.
- R10: With length 1 and the enable at 1, every byte carries both `m_sof` and `m_eof`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` |
| s_valid | input | 1 | Source byte valid |
| s_data | input | 8 | Source byte |
| s_last | input | 1 | Source end of data |
| s_ready | output | 1 | Source byte accepted when high with `s_valid` |
| m_valid | output | 1 | Output byte valid |
| m_data | output | 8 | Output byte |
| m_sof | output | 1 | Output byte starts a frame |
| m_eof | output | 1 | Output byte ends a frame |
| m_ready | input | 1 | Downstream ready |

## Verification
The bench covers several cases that a faulty design would get wrong:
- A 12-byte transfer at length 5 must give frames of 5, 5 and 2. An off-by-one in the down counter would move every boundary by a byte.
- At length 1, every byte must carry both markers. A counter that loads N instead of N-1 would mark only every second byte.
- The bench rewrites the length and turns the enable off in the middle of a frame. A design that reads the live registers would end the frame early.
- With length 0 or the enable off, the transfer must stay one frame. A design that treats length 0 as 8192 or as 1 would cut it.
- During stalls, the bench reads the remaining count. A design that counts offered rather than accepted bytes would show a drop.

// File: rtl/txseg_pkg.sv
// Package: shared register selectors for the transmit frame segmenter.
// Assumes a 2-bit register address and an 8-bit register data path.
package txseg_pkg;
    localparam int unsigned REG_ADDR_W = 2;
    localparam int unsigned REG_DATA_W = 8;

    typedef enum logic [REG_ADDR_W-1:0] {
        SEL_LEN_LO = 2'd0,
        SEL_LEN_HI = 2'd1,
        SEL_CTRL   = 2'd2,
        SEL_SPARE  = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/txseg_regs.sv
// Module: txseg_regs
// Holds the programmed frame length and the segmentation enable, and
// drives the read data mux. The length fields read back the remaining
// count supplied by the frame controller. Assumes 8 < LEN_W <= 16.
module txseg_regs
    import txseg_pkg::*;
#(
    parameter int unsigned LEN_W = 13
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reg_we,
    input  logic [REG_ADDR_W-1:0] reg_addr,
    input  logic [REG_DATA_W-1:0] reg_wdata,
    input  logic [LEN_W-1:0]      rem_count,
    output logic [REG_DATA_W-1:0] reg_rdata,
    output logic [LEN_W-1:0]      cfg_len,
    output logic                  cfg_auto
);
    localparam int unsigned HI_W = LEN_W - REG_DATA_W;

    logic [REG_DATA_W-1:0] len_lo_q;
    logic [HI_W-1:0]       len_hi_q;
    logic                  auto_q;

    // Register writes: length halves and the enable bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_lo_q <= '0;
            len_hi_q <= '0;
            auto_q   <= 1'b0;
        end else if (reg_we) begin
            case (reg_sel_e'(reg_addr))
                SEL_LEN_LO: len_lo_q <= reg_wdata;
                SEL_LEN_HI: len_hi_q <= reg_wdata[HI_W-1:0];
                SEL_CTRL:   auto_q   <= reg_wdata[0];
                default:    ;
            endcase
        end
    end

    assign cfg_len  = {len_hi_q, len_lo_q};
    assign cfg_auto = auto_q;

    // Read mux: length fields show the remaining count, control shows the enable.
    always_comb begin
        reg_rdata = '0;
        case (reg_sel_e'(reg_addr))
            SEL_LEN_LO: reg_rdata = rem_count[REG_DATA_W-1:0];
            SEL_LEN_HI: reg_rdata = REG_DATA_W'(rem_count[LEN_W-1:REG_DATA_W]);
            SEL_CTRL:   reg_rdata = {{(REG_DATA_W-1){1'b0}}, auto_q};
            default:    reg_rdata = '0;
        endcase
    end

    // R2: a high-half write lands in length bits 12:8 one cycle later.
    a_r2_hi_write: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we && reg_addr == SEL_LEN_HI |=> cfg_len[LEN_W-1:REG_DATA_W] == $past(reg_wdata[HI_W-1:0]));

    // R2: a control write sets the enable from write-data bit 0.
    a_r2_ctrl_write: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we && reg_addr == SEL_CTRL |=> cfg_auto == $past(reg_wdata[0]));
endmodule

// File: rtl/txseg_frame_ctrl.sv
// Module: txseg_frame_ctrl
// Tracks the open frame and decides the start and end markers of the
// byte being offered. The length and the enable are captured when the
// first byte of a frame is accepted. Assumes beat is valid AND ready.
module txseg_frame_ctrl #(
    parameter int unsigned LEN_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             beat,
    input  logic             src_last,
    input  logic [LEN_W-1:0] cfg_len,
    input  logic             cfg_auto,
    output logic             frame_sof,
    output logic             frame_eof,
    output logic [LEN_W-1:0] rem_count
);
    logic             in_frame_q;
    logic             seg_q;
    logic [LEN_W-1:0] left_q;

    logic             start_seg;
    logic             cur_seg;
    logic [LEN_W-1:0] cur_left;

    // Marker decision for the offered byte, using captured or live settings.
    always_comb begin
        start_seg = cfg_auto && (cfg_len != '0);
        cur_seg   = in_frame_q ? seg_q  : start_seg;
        cur_left  = in_frame_q ? left_q : cfg_len;
        frame_sof = !in_frame_q;
        frame_eof = src_last || (cur_seg && cur_left == LEN_W'(1));
        rem_count = in_frame_q ? left_q : cfg_len;
    end

    // Frame state: open, captured mode and bytes left, advanced per accepted byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_frame_q <= 1'b0;
            seg_q      <= 1'b0;
            left_q     <= '0;
        end else if (beat) begin
            if (frame_eof) begin
                in_frame_q <= 1'b0;
                seg_q      <= 1'b0;
                left_q     <= '0;
            end else begin
                in_frame_q <= 1'b1;
                seg_q      <= cur_seg;
                left_q     <= cur_seg ? cur_left - LEN_W'(1) : '0;
            end
        end
    end

    // R3: an accepted end byte closes the frame.
    a_r3_end_closes: assert property (@(posedge clk) disable iff (!rst_n)
        beat && frame_eof |=> !in_frame_q);

    // R3: a segmented open frame always has bytes left.
    a_r3_left_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        in_frame_q && seg_q |-> left_q != '0);

    // R7: each accepted middle byte of a segmented frame takes one off the count.
    a_r7_count_down: assert property (@(posedge clk) disable iff (!rst_n)
        beat && in_frame_q && seg_q && !frame_eof |=> left_q == $past(left_q) - LEN_W'(1));

    // R7: an unsegmented open frame reads a zero count.
    a_r7_unseg_zero: assert property (@(posedge clk) disable iff (!rst_n)
        in_frame_q && !seg_q |-> left_q == '0);

    // R9: a cycle without a transfer leaves the frame state alone.
    a_r9_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !beat |=> $stable(in_frame_q) && $stable(left_q) && $stable(seg_q));
endmodule

// File: rtl/tx_frame_segmenter.sv
// Module: tx_frame_segmenter
// Top of the transmit frame segmenter. Passes bytes straight from source
// to sink and tags them with frame markers, with no storage in the path.
// Assumes the downstream framer only samples markers on accepted bytes.
module tx_frame_segmenter
    import txseg_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned LEN_W  = 13
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reg_we,
    input  logic [REG_ADDR_W-1:0] reg_addr,
    input  logic [REG_DATA_W-1:0] reg_wdata,
    output logic [REG_DATA_W-1:0] reg_rdata,
    input  logic                  s_valid,
    input  logic [DATA_W-1:0]     s_data,
    input  logic                  s_last,
    output logic                  s_ready,
    output logic                  m_valid,
    output logic [DATA_W-1:0]     m_data,
    output logic                  m_sof,
    output logic                  m_eof,
    input  logic                  m_ready
);
    logic [LEN_W-1:0] cfg_len;
    logic             cfg_auto;
    logic [LEN_W-1:0] rem_count;
    logic             beat;
    logic             frame_sof;
    logic             frame_eof;

    assign beat = s_valid && m_ready;

    txseg_regs #(.LEN_W(LEN_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .rem_count (rem_count),
        .reg_rdata (reg_rdata),
        .cfg_len   (cfg_len),
        .cfg_auto  (cfg_auto)
    );

    txseg_frame_ctrl #(.LEN_W(LEN_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .beat      (beat),
        .src_last  (s_last),
        .cfg_len   (cfg_len),
        .cfg_auto  (cfg_auto),
        .frame_sof (frame_sof),
        .frame_eof (frame_eof),
        .rem_count (rem_count)
    );

    // Pass-through path: handshake and data flow straight across.
    always_comb begin
        m_valid = s_valid;
        s_ready = m_ready;
        m_data  = s_data;
        m_sof   = s_valid && frame_sof;
        m_eof   = s_valid && frame_eof;
    end

    // R4: an accepted end-of-data byte always ends its frame.
    a_r4_last_ends: assert property (@(posedge clk) disable iff (!rst_n)
        beat && s_last |-> m_eof);

    // R3: the byte after an accepted end byte starts a new frame.
    a_r3_next_starts: assert property (@(posedge clk) disable iff (!rst_n)
        beat && m_eof ##1 s_valid |-> m_sof);
endmodule

// File: tb/tb_tx_frame_segmenter.sv
`timescale 1ns/1ps
module tb_tx_frame_segmenter;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_we = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       s_valid = 1'b0;
    logic [7:0] s_data = 8'd0;
    logic       s_last = 1'b0;
    logic       s_ready;
    logic       m_valid;
    logic [7:0] m_data;
    logic       m_sof;
    logic       m_eof;
    logic       m_ready = 1'b1;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    int stall_mode = 0;
    int cyc = 0;

    logic [9:0] exp_q[$];

    // Bench model of the programmed settings and of the open frame.
    logic [12:0] len_cfg = 13'd0;
    bit          en_cfg = 1'b0;
    bit          mdl_in = 1'b0;
    bit          mdl_seg = 1'b0;
    logic [12:0] mdl_left = 13'd0;

    tx_frame_segmenter dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .s_valid(s_valid),
        .s_data(s_data), .s_last(s_last), .s_ready(s_ready), .m_valid(m_valid),
        .m_data(m_data), .m_sof(m_sof), .m_eof(m_eof), .m_ready(m_ready)
    );

    always #4 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (stall_mode == 1) m_ready <= (cyc % 3) != 0;
        else if (stall_mode == 2) m_ready <= 1'b0;
        else m_ready <= 1'b1;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Monitor: pops the expected byte for every accepted output byte.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(s_ready == m_ready && m_valid == s_valid, "R9 handshake pass", s_ready, m_ready);
            if (m_valid && m_ready) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R9 unexpected byte", m_data, 0);
                end else begin
                    logic [9:0] e;
                    e = exp_q.pop_front();
                    chk({m_data, m_sof, m_eof} == e, "R3 R4 R5 R6 R10 byte/markers",
                        {m_data, m_sof, m_eof}, e);
                end
            end
        end
    end

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_we = 1'b0;
        if (a == 2'd0) len_cfg[7:0] = d;
        if (a == 2'd1) len_cfg[12:8] = d[4:0];
        if (a == 2'd2) en_cfg = d[0];
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        reg_addr = a; #1; d = reg_rdata;
    endtask

    task automatic set_len(input int n);
        wr(2'd0, n[7:0]);
        wr(2'd1, {3'b000, n[12:8]});
    endtask

    task automatic check_rem(input string tag);
        logic [7:0] lo, hi;
        logic [12:0] exp;
        rd(2'd0, lo); rd(2'd1, hi);
        exp = mdl_in ? mdl_left : len_cfg;
        chk({hi[4:0], lo} == exp && hi[7:5] == 3'b000, tag, {hi, lo}, exp);
    endtask

    // Driver: predicts the markers, queues the expectation, then offers the byte.
    task automatic send_byte(input logic [7:0] d, input bit last);
        bit sof, eof;
        sof = !mdl_in;
        if (!mdl_in) begin
            mdl_seg  = en_cfg && len_cfg != 13'd0;
            mdl_left = len_cfg;
        end
        eof = last || (mdl_seg && mdl_left == 13'd1);
        exp_q.push_back({d, sof, eof});
        if (eof) begin mdl_in = 1'b0; mdl_left = 13'd0; end
        else begin mdl_in = 1'b1; mdl_left = mdl_seg ? mdl_left - 13'd1 : 13'd0; end
        s_valid = 1'b1; s_data = d; s_last = last;
        forever begin
            @(negedge clk);
            if (m_ready) break;
        end
        @(posedge clk); #1;
        s_valid = 1'b0; s_last = 1'b0;
    endtask

    task automatic send_run(input int n, input logic [7:0] base);
        for (int i = 0; i < n; i++) send_byte(base + 8'(i), i == n - 1);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;

        // R1: reset state
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), v);
            chk(v == 8'h00, "R1 reset read", v, 0);
        end
        chk(s_ready == m_ready, "R1 ready follows", s_ready, m_ready);

        // R2: field mapping, ignored high bits, spare address
        wr(2'd1, 8'hF2); wr(2'd0, 8'h34);
        rd(2'd1, v); chk(v == 8'h12, "R2 high half", v, 8'h12);
        rd(2'd0, v); chk(v == 8'h34, "R2 low half", v, 8'h34);
        wr(2'd2, 8'hFF);
        rd(2'd2, v); chk(v == 8'h01, "R2 ctrl bits", v, 8'h01);
        wr(2'd3, 8'hAA);
        rd(2'd3, v); chk(v == 8'h00, "R2 spare address", v, 0);
        check_rem("R7 idle reads length 0x1234");

        // R3 R4: length 5, 12 bytes -> 5,5,2
        set_len(5);
        check_rem("R7 idle reads 5");
        for (int i = 0; i < 12; i++) begin
            send_byte(8'h10 + 8'(i), i == 11);
            check_rem("R7 segmented count");
        end

        // R10: length 1
        set_len(1);
        send_run(4, 8'h40);

        // R5: enable off, length 5, 8 bytes single frame, count reads 0
        set_len(5); wr(2'd2, 8'h00);
        for (int i = 0; i < 8; i++) begin
            send_byte(8'h50 + 8'(i), i == 7);
            check_rem("R7 R5 unsegmented count");
        end

        // R6: length 0 with enable on
        wr(2'd2, 8'h01); set_len(0);
        send_run(7, 8'h60);

        // R8: rewrite settings mid-frame
        set_len(4);
        send_byte(8'h70, 1'b0); send_byte(8'h71, 1'b0);
        set_len(2); wr(2'd2, 8'h00);
        check_rem("R8 count unchanged by write");
        for (int i = 2; i < 8; i++) send_byte(8'h70 + 8'(i), i == 7);

        // R9: stalls do not advance the count
        wr(2'd2, 8'h01); set_len(3);
        send_byte(8'h80, 1'b0);
        stall_mode = 2;
        @(posedge clk); #1;
        s_valid = 1'b1; s_data = 8'h81;
        repeat (3) @(posedge clk); #1;
        check_rem("R9 count held in stall");
        chk(exp_q.size() == 0, "R9 no transfer in stall", exp_q.size(), 0);
        s_valid = 1'b0;
        stall_mode = 1;
        for (int i = 1; i < 7; i++) send_byte(8'h80 + 8'(i), i == 6);
        stall_mode = 0;

        // R3: wide length, 302 bytes -> 300,2
        set_len(300);
        send_run(302, 8'h00);

        repeat (4) @(posedge clk);
        chk(exp_q.size() == 0, "R9 all bytes seen", exp_q.size(), 0);
        finish_run();
    end
endmodule